// File: doc/BRIEF.md
# Paired-Instruction Fetch and Execute Unit

This unit sequences instruction fetch for a stored-program accumulator machine in which every 40-bit memory word packs two 20-bit instructions. Each instruction has an 8-bit operation code and a 12-bit operand address. The unit reads a word from memory and runs its left instruction. It keeps the right instruction in an internal buffer, so that instruction then issues with no memory access. The program counter therefore moves forward once per word, not once per instruction.

One synchronous memory serves both code and data. It has a one-cycle read latency and sits behind a single address/read/write interface. Instruction reads and operand accesses are spread over separate phases and never share a cycle. A small execute stage handles load, add and store on the accumulator, so fetch ordering and buffering can be seen at the pins. A phase output reports which step the sequencer is in on every cycle. A one-bit entry input, sampled during reset, lets execution start at the right-hand instruction of the first word.

Top module: `pairfetch_unit`

## Requirements
- R1: While reset is held and on the first cycle after it is released, `pc` = 0, `acc` = 0, `phase` = 0 (fetch), and neither `memRd` nor `memWr` is asserted.
- R2: A fetched word is split with bit 39 as the most significant bit. The left instruction has its opcode in [39:32] and its address in [31:20]. The right instruction has its opcode in [19:12] and its address in [11:0]. The left instruction executes first, and `pc` still holds the word's address while it does.
- R3: Exactly one instruction read (`memRd` with `memAddr` equal to `pc`) is made per word. The buffered right instruction issues from a fetch cycle with no memory access, and `pc` advances by one when it issues. The buffer is empty afterwards.
- R4: `phase` codes are 0 fetch, 1 memory read, 2 split, 3 decode, 4 execute. A word that starts from an empty buffer runs 0,1,2,3,4. A buffered instruction runs 0,3,4.
- R5: Opcode 8'h01 loads `acc` from the operand. Opcode 8'h05 adds the operand to `acc`, wrapping modulo 2^40. Opcode 8'h21 writes `acc` to the operand address: `memWr` is asserted in the execute phase with `memWdata` = `acc`. Every other opcode makes no memory access and leaves `acc` unchanged. The new `acc` is visible in the next fetch cycle.
- R6: Read data is consumed on the cycle after `memRd`. Instruction reads are consumed in the split phase. Load and add reads are issued in decode and consumed in execute.
- R7: `memRd` and `memWr` are never asserted together. No memory access happens in the fetch, split or (for reads) execute phases, except as R3, R5 and R6 state.
- R8: No access is ever issued with `memAddr` ≥ 1000. An instruction whose operand address is ≥ 1000 makes no access and leaves `acc` and memory unchanged.
- R9: `pc` stays below 1000 and advances from 999 to 0.
- R10: With `entryRight` = 1 during reset, the first word runs only its right instruction: `pc` advances at the split and nothing is buffered. Later words follow R2 and R3.
- R11: With word 1 holding {load 500, add 501} and words 500 and 501 holding 3 and 4, `acc` is 7 once both instructions have run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| entryRight | input | 1 | Sampled in reset: start at the right instruction of the first word |
| memRdata | input | 40 | Read data, valid the cycle after `memRd` |
| memAddr | output | 12 | Memory word address |
| memRd | output | 1 | Memory read strobe |
| memWr | output | 1 | Memory write strobe |
| memWdata | output | 40 | Memory write data |
| acc | output | 40 | Accumulator |
| pc | output | 12 | Program counter (word address) |
| phase | output | 3 | Current sequencer phase code |

## Verification
Every result has a fixed due cycle.
- The instruction read appears in the cycle after the fetch phase.
- Load and add reads are issued in decode.
- The store strobe appears in execute.
- The new accumulator value is due in the fetch cycle that follows execute.

The bench samples on the falling edge and walks each word through its expected phase string (0,1,2,3,4 then 0,3,4). At each step it checks the phase code, the strobes, the address and the data, so a result that comes one cycle early or late is caught. A reference interpreter in the bench, written from the encodings above, supplies the expected accumulator and memory contents for randomised programs, the entry-right start and a full program-counter wrap.

// File: rtl/pairfetch_pkg.sv
package pairfetch_pkg;

  typedef enum logic [2:0] {
    PH_FETCH  = 3'd0,
    PH_MEMRD  = 3'd1,
    PH_SPLIT  = 3'd2,
    PH_DECODE = 3'd3,
    PH_EXEC   = 3'd4
  } phase_e;

  localparam logic [7:0] OPC_LOAD  = 8'h01;
  localparam logic [7:0] OPC_ADD   = 8'h05;
  localparam logic [7:0] OPC_STORE = 8'h21;

  // Strobes from the sequencer to the register datapath.
  typedef struct packed {
    logic takeBuffered;  // issue right instruction from the buffer
    logic marFromPc;     // address register takes the program counter
    logic instrRead;     // instruction word read
    logic splitWord;     // split returned word into instruction fields
    logic operandRead;   // operand read for load/add
    logic mbrFromAc;     // stage accumulator into the buffer register
    logic operandWrite;  // write staged accumulator to memory
    logic acLoad;        // accumulator takes returned data
    logic acAdd;         // accumulator adds returned data
  } strobe_t;

endpackage

// File: rtl/pairfetch_ctrl.sv
module pairfetch_ctrl
  import pairfetch_pkg::*;
#(
  parameter int OP_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            ibrValid,
  input  logic [OP_W-1:0] opcode,
  input  logic            marOk,
  output strobe_t         strobe,
  output phase_e          phase,
  output logic            memRd,
  output logic            memWr
);

  phase_e state;
  phase_e nextState;
  logic   loadIssued;
  logic   addIssued;
  logic   isLoad;
  logic   isAdd;
  logic   isStore;

  assign isLoad  = (opcode == OP_W'(OPC_LOAD));
  assign isAdd   = (opcode == OP_W'(OPC_ADD));
  assign isStore = (opcode == OP_W'(OPC_STORE));

  always_comb begin
    strobe    = '0;
    nextState = state;
    unique case (state)
      PH_FETCH: begin
        if (ibrValid) begin
          strobe.takeBuffered = 1'b1;
          nextState           = PH_DECODE;
        end else begin
          strobe.marFromPc = 1'b1;
          nextState        = PH_MEMRD;
        end
      end
      PH_MEMRD: begin
        strobe.instrRead = 1'b1;
        nextState        = PH_SPLIT;
      end
      PH_SPLIT: begin
        strobe.splitWord = 1'b1;
        nextState        = PH_DECODE;
      end
      PH_DECODE: begin
        strobe.operandRead = marOk && (isLoad || isAdd);
        strobe.mbrFromAc   = isStore;
        nextState          = PH_EXEC;
      end
      PH_EXEC: begin
        strobe.acLoad       = loadIssued;
        strobe.acAdd        = addIssued;
        strobe.operandWrite = marOk && isStore;
        nextState           = PH_FETCH;
      end
      default: nextState = PH_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= PH_FETCH;
      loadIssued <= 1'b0;
      addIssued  <= 1'b0;
    end else begin
      state      <= nextState;
      loadIssued <= strobe.operandRead && isLoad;
      addIssued  <= strobe.operandRead && isAdd;
    end
  end

  assign phase = state;
  assign memRd = strobe.instrRead | strobe.operandRead;
  assign memWr = strobe.operandWrite;

  // R7: an instruction read never overlaps an operand access
  assert_single_access_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.instrRead |-> !strobe.operandRead && !strobe.operandWrite);

  // R3: a buffered instruction goes straight to decode, skipping memory
  assert_buffer_skips_read_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == PH_FETCH && ibrValid) |=> (state == PH_DECODE && !strobe.instrRead));

  // R6: split only ever follows the instruction read one cycle earlier
  assert_split_after_read_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == PH_SPLIT) |-> ($past(state) == PH_MEMRD && $past(memRd)));

  // R6: accumulator update only consumes data from a read the cycle before
  assert_ac_needs_read_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.acLoad || strobe.acAdd) |-> $past(memRd));

  // R4: phase code always one of the five legal values
  assert_phase_legal_R4: assert property (@(posedge clk) disable iff (!rstN)
    state inside {PH_FETCH, PH_MEMRD, PH_SPLIT, PH_DECODE, PH_EXEC});

endmodule

// File: rtl/pairfetch_dp.sv
module pairfetch_dp
  import pairfetch_pkg::*;
#(
  parameter int OP_W   = 8,
  parameter int ADDR_W = 12,
  parameter int DEPTH  = 1000,
  localparam int INSTR_W = OP_W + ADDR_W,
  localparam int WORD_W  = 2 * INSTR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              entryRight,
  input  strobe_t           strobe,
  input  logic [WORD_W-1:0] memRdata,
  output logic              ibrValid,
  output logic [OP_W-1:0]   opcode,
  output logic              marOk,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  output logic [WORD_W-1:0] acc
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

  logic [ADDR_W-1:0]  pcReg;
  logic [ADDR_W-1:0]  mar;
  logic [WORD_W-1:0]  mbr;
  logic [OP_W-1:0]    ir;
  logic [INSTR_W-1:0] ibr;
  logic               ibrFull;
  logic               needRight;
  logic [WORD_W-1:0]  ac;

  logic [INSTR_W-1:0] leftInstr;
  logic [INSTR_W-1:0] rightInstr;
  logic [ADDR_W-1:0]  pcNext;

  assign leftInstr  = memRdata[WORD_W-1 -: INSTR_W];
  assign rightInstr = memRdata[INSTR_W-1:0];
  assign pcNext     = (pcReg == LAST_ADDR) ? '0 : pcReg + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcReg     <= '0;
      mar       <= '0;
      mbr       <= '0;
      ir        <= '0;
      ibr       <= '0;
      ibrFull   <= 1'b0;
      needRight <= entryRight;
      ac        <= '0;
    end else begin
      if (strobe.takeBuffered) begin
        ir      <= ibr[INSTR_W-1 -: OP_W];
        mar     <= ibr[ADDR_W-1:0];
        pcReg   <= pcNext;
        ibrFull <= 1'b0;
      end
      if (strobe.marFromPc) begin
        mar <= pcReg;
      end
      if (strobe.splitWord) begin
        mbr <= memRdata;
        if (needRight) begin
          ir        <= rightInstr[INSTR_W-1 -: OP_W];
          mar       <= rightInstr[ADDR_W-1:0];
          pcReg     <= pcNext;
          needRight <= 1'b0;
        end else begin
          ibr     <= rightInstr;
          ibrFull <= 1'b1;
          ir      <= leftInstr[INSTR_W-1 -: OP_W];
          mar     <= leftInstr[ADDR_W-1:0];
        end
      end
      if (strobe.mbrFromAc) begin
        mbr <= ac;
      end
      if (strobe.acLoad) begin
        mbr <= memRdata;
        ac  <= memRdata;
      end
      if (strobe.acAdd) begin
        mbr <= memRdata;
        ac  <= ac + memRdata;
      end
    end
  end

  assign ibrValid = ibrFull;
  assign opcode   = ir;
  assign marOk    = (mar <= LAST_ADDR);
  assign pc       = pcReg;
  assign memAddr  = mar;
  assign memWdata = mbr;
  assign acc      = ac;

  // R8: every memory access targets an existing word
  assert_addr_range_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.instrRead || strobe.operandRead || strobe.operandWrite) |-> (mar <= LAST_ADDR));

  // R9: program counter steps by one or wraps from the last word to zero
  assert_pc_stride_R9: assert property (@(posedge clk) disable iff (!rstN)
    (pcReg != $past(pcReg)) |->
      ((pcReg == $past(pcReg) + 1'b1) || ($past(pcReg) == LAST_ADDR && pcReg == '0)));

  // R9: program counter never leaves the memory
  assert_pc_bound_R9: assert property (@(posedge clk) disable iff (!rstN)
    pcReg <= LAST_ADDR);

  // R3: the buffered instruction is consumed exactly once
  assert_ibr_consumed_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.takeBuffered |=> !ibrFull);

  // R5: a store writes the value the accumulator held when it was staged
  assert_store_data_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.operandWrite |-> (mbr == $past(ac)));

endmodule

// File: rtl/pairfetch_unit.sv
module pairfetch_unit
  import pairfetch_pkg::*;
#(
  parameter int OP_W   = 8,
  parameter int ADDR_W = 12,
  parameter int DEPTH  = 1000,
  localparam int WORD_W = 2 * (OP_W + ADDR_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              entryRight,
  input  logic [WORD_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRd,
  output logic              memWr,
  output logic [WORD_W-1:0] memWdata,
  output logic [WORD_W-1:0] acc,
  output logic [ADDR_W-1:0] pc,
  output logic [2:0]        phase
);

  strobe_t         strobe;
  phase_e          phaseState;
  logic            ibrValid;
  logic [OP_W-1:0] opcode;
  logic            marOk;

  pairfetch_ctrl #(
    .OP_W(OP_W)
  ) ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .ibrValid(ibrValid),
    .opcode  (opcode),
    .marOk   (marOk),
    .strobe  (strobe),
    .phase   (phaseState),
    .memRd   (memRd),
    .memWr   (memWr)
  );

  pairfetch_dp #(
    .OP_W  (OP_W),
    .ADDR_W(ADDR_W),
    .DEPTH (DEPTH)
  ) dp (
    .clk       (clk),
    .rstN      (rstN),
    .entryRight(entryRight),
    .strobe    (strobe),
    .memRdata  (memRdata),
    .ibrValid  (ibrValid),
    .opcode    (opcode),
    .marOk     (marOk),
    .pc        (pc),
    .memAddr   (memAddr),
    .memWdata  (memWdata),
    .acc       (acc)
  );

  assign phase = phaseState;

endmodule

// File: tb/pairfetch_unit_test.sv
`timescale 1ns/1ps
module pairfetch_unit_test;

  localparam int DEPTH = 1000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        entryRight = 1'b0;
  logic [39:0] memRdata = '0;
  logic [11:0] memAddr;
  logic        memRd;
  logic        memWr;
  logic [39:0] memWdata;
  logic [39:0] acc;
  logic [11:0] pc;
  logic [2:0]  phase;

  always #2.5 clk = ~clk;

  pairfetch_unit uut (
    .clk(clk), .rstN(rstN), .entryRight(entryRight), .memRdata(memRdata),
    .memAddr(memAddr), .memRd(memRd), .memWr(memWr), .memWdata(memWdata),
    .acc(acc), .pc(pc), .phase(phase)
  );

  logic [39:0] mem    [DEPTH];
  logic [39:0] refMem [DEPTH];
  logic [39:0] refAc;
  logic [31:0] seed = 32'h1234_5678;
  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  logic [7:0] opTab [6] = '{8'h01, 8'h05, 8'h21, 8'h00, 8'h05, 8'hC3};

  // One-cycle-latency shared memory model
  always @(posedge clk) begin
    if (memRd) memRdata <= (memAddr < 12'(DEPTH)) ? mem[memAddr] : '0;
    if (memWr && memAddr < 12'(DEPTH)) mem[memAddr] <= memWdata;
  end

  task automatic checkEq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  task automatic setWord(input int a, input logic [39:0] v);
    mem[a]    = v;
    refMem[a] = v;
  endtask

  task automatic clearMem();
    for (int a = 0; a < DEPTH; a++) setWord(a, '0);
  endtask

  // Runs D and E of one instruction and lands on the following fetch cycle.
  task automatic execInstr(input logic [19:0] ins);
    logic [7:0]  op;
    logic [11:0] a;
    bit inR, rd, wr;
    op  = ins[19:12];
    a   = ins[11:0];
    inR = (a < 12'(DEPTH));
    rd  = inR && (op == 8'h01 || op == 8'h05);
    wr  = inR && (op == 8'h21);
    checkEq("R4 decode phase", phase, 3);
    checkEq("R5 R8 operand read strobe", memRd, rd);
    checkEq("R7 no write in decode", memWr, 0);
    if (rd) checkEq("R6 operand read address", memAddr, a);
    @(negedge clk);
    checkEq("R4 execute phase", phase, 4);
    checkEq("R5 R8 store strobe", memWr, wr);
    checkEq("R7 no read in execute", memRd, 0);
    if (wr) begin
      checkEq("R5 store address", memAddr, a);
      checkEq("R5 store data", memWdata, refAc);
    end
    if (rd && op == 8'h01) refAc = refMem[a];
    if (rd && op == 8'h05) refAc = refAc + refMem[a];
    if (wr) refMem[a] = refAc;
    @(negedge clk);
    checkEq("R5 accumulator after instruction", acc, refAc);
  endtask

  task automatic runProgram(input int nWords, input bit rightFirst);
    logic [39:0] word;
    bit doLeft;
    rstN = 1'b0;
    entryRight = rightFirst;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    refAc = '0;
    checkEq("R1 pc after reset", pc, 0);
    checkEq("R1 acc after reset", acc, 0);
    checkEq("R1 phase after reset", phase, 0);
    for (int w = 0; w < nWords; w++) begin
      word   = refMem[w];
      doLeft = !(rightFirst && w == 0);
      checkEq("R4 fetch phase", phase, 0);
      checkEq("R7 no access in fetch", memRd | memWr, 0);
      @(negedge clk);
      checkEq("R4 memory read phase", phase, 1);
      checkEq("R3 instruction read strobe", memRd, 1);
      checkEq("R3 instruction read address", memAddr, 12'(w));
      @(negedge clk);
      checkEq("R4 split phase", phase, 2);
      checkEq("R7 no access in split", memRd | memWr, 0);
      @(negedge clk);
      if (doLeft) begin
        execInstr(word[39:20]);
        checkEq("R2 pc held during left instruction", pc, 12'(w));
        checkEq("R4 buffered fetch phase", phase, 0);
        checkEq("R3 no read for buffered instruction", memRd | memWr, 0);
        @(negedge clk);
        execInstr(word[19:0]);
      end else begin
        execInstr(word[19:0]);
      end
      checkEq("R3 R9 R10 pc after word", pc, 12'((w + 1) % DEPTH));
    end
  endtask

  initial begin
    // R1: state while reset is held
    repeat (2) @(negedge clk);
    checkEq("R1 pc in reset", pc, 0);
    checkEq("R1 acc in reset", acc, 0);
    checkEq("R1 phase in reset", phase, 0);
    checkEq("R1 no strobes in reset", memRd | memWr, 0);

    // R11: canonical two-instruction word
    clearMem();
    setWord(1, {8'h01, 12'd500, 8'h05, 12'd501});
    setWord(500, 40'd3);
    setWord(501, 40'd4);
    runProgram(2, 1'b0);
    checkEq("R11 accumulator holds 7", acc, 40'd7);

    // R10: entry at the right-hand instruction of word 0
    clearMem();
    setWord(0, {8'h05, 12'd500, 8'h01, 12'd501});
    setWord(1, {8'h05, 12'd500, 8'h21, 12'd502});
    setWord(500, 40'd9);
    setWord(501, 40'd2);
    runProgram(2, 1'b1);
    checkEq("R10 accumulator skips left add", acc, 40'd11);
    checkEq("R10 stored value", mem[502], 40'd11);

    // R2 R5 R8: randomised programs against the reference interpreter
    for (int p = 0; p < 6; p++) begin
      logic [31:0] r;
      logic [19:0] ins [2];
      clearMem();
      for (int a = 500; a < DEPTH; a++) begin
        r = rnd();
        setWord(a, {r[7:0], rnd()});
      end
      setWord(999, 40'hFF_FFFF_FFFF);
      for (int w = 0; w < 40; w++) begin
        for (int h = 0; h < 2; h++) begin
          r = rnd();
          ins[h][19:12] = opTab[r % 6];
          ins[h][11:0]  = (r[10:8] == 3'd0) ? 12'(1000 + (r >> 12) % 3000)
                                            : 12'(500 + (r >> 12) % 500);
        end
        setWord(w, {ins[0], ins[1]});
      end
      runProgram(40, p == 5);
      for (int a = 500; a < DEPTH; a++)
        checkEq("R5 R8 memory contents after program", mem[a], refMem[a]);
    end

    // R9: full sweep of no-op words wraps the program counter
    clearMem();
    runProgram(DEPTH, 1'b0);
    checkEq("R9 pc wrapped to zero", pc, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule